// File: doc/BRIEF.md
# Battery-Backed SRAM Bank Enable Guard

This block sits between a memory controller's active-low chip-enable and up to four banks of battery-backed static RAM. While the supply is healthy it behaves as a transparent decoder: a two-bit bank select picks one bank enable, and that enable follows the incoming chip-enable with no register in the path. All other bank enables stay high (inactive).

The supply is observed as an unsigned millivolt code, sampled on each clock edge. It is compared against one of two thresholds, chosen by a tolerance-select input. Once a sampling edge sees the code below the threshold, the banks are write-protected. An access already under way when the fault is first seen may finish on the bank it started on, but only for a bounded number of clock cycles. After that, every enable is driven high.

After reset, or after any fault, the block stays locked out. It leaves lockout only after the supply code has stayed good for a programmable run of consecutive samples, and only while the chip-enable input is idle.

Top module: `sram_bank_guard`

## Requirements
- R1: In the pass-through state, the enable bit numbered by the select code {B,A} equals the chip-enable input combinationally. Code 00 maps to bit 0 and code 11 maps to bit 3. Every other bit is 1.
- R2: At no time is more than one bank enable output low.
- R3: A supply sample counts as faulty when the code is strictly below 4620 with the tolerance select at 0, or strictly below 4370 with the tolerance select at 1. A code equal to the threshold counts as good.
- R4: A faulty sample taken while the chip-enable input is high (idle) locks the block out from that clock edge. All enables are then 1 whatever the chip-enable input does.
- R5: A faulty sample taken while the chip-enable input is low freezes the bank in use. That bank's enable keeps following the chip-enable input and select changes are ignored. At the first edge that samples the chip-enable high, the block locks out.
- R6: If the chip-enable input is still low TIMEOUT_CYC edges after the fault edge, all enables are 1 from that edge on.
- R7: While locked out, every enable output is 1, and a falling chip-enable input has no effect.
- R8: The block leaves lockout only at an edge whose sample is good and which follows VALID_CYC consecutive good samples. Any faulty sample restarts that count.
- R9: During reset and after its release, the block is in lockout and must qualify the supply as in R8.
- R10: An exit from lockout happens only at an edge where the chip-enable input is high. A low chip-enable holds the block in lockout even when the supply is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ce_n | input | 1 | Active-low chip-enable from the memory controller |
| bank_sel | input | SEL_W (2) | Bank select code {B,A} |
| supply_mv | input | SUPPLY_W (13) | Sampled supply level in millivolts, unsigned |
| tol_wide | input | 1 | 0 selects the 4620 mV threshold, 1 selects the 4370 mV threshold |
| bank_ce_n | output | NUM_BANKS (4) | Active-low bank enables, bit 0 is bank 1 |

## Verification
The bench builds the block with TIMEOUT_CYC = 6 and VALID_CYC = 4 instead of the much longer defaults. With these values, the exact edge at which a stuck access is cut off can be observed within a handful of cycles. The same holds for the edge at which a recovering supply is first accepted. The short values also let the test restart qualification with a single dip, and show that a held-low chip-enable delays the exit from lockout.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  // Guard states: locked out, transparent pass-through, draining a cut-off access
  typedef enum logic [1:0] {
    GS_LOCKED = 2'd0,
    GS_RUN    = 2'd1,
    GS_DRAIN  = 2'd2
  } guard_state_t;

endpackage

// File: rtl/reset_sync.sv
module reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  // Asynchronous assertion, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/supply_qualifier.sv
module supply_qualifier #(
  parameter int SUPPLY_W    = 13,
  parameter int TH_TIGHT_MV = 4620,
  parameter int TH_LOOSE_MV = 4370,
  parameter int VALID_CYC   = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SUPPLY_W-1:0] supply_mv,
  input  logic                tol_wide,
  output logic                below,
  output logic                supply_ok
);

  localparam int QW = $clog2(VALID_CYC + 1);
  localparam logic [QW-1:0]       QMAX     = QW'(VALID_CYC);
  localparam logic [SUPPLY_W-1:0] TH_TIGHT = SUPPLY_W'(TH_TIGHT_MV);
  localparam logic [SUPPLY_W-1:0] TH_LOOSE = SUPPLY_W'(TH_LOOSE_MV);

  logic [SUPPLY_W-1:0] thresh;
  logic [QW-1:0]       good_q, good_d;
  logic                good_en;

  // Threshold choice and fault compare
  always_comb begin
    thresh = tol_wide ? TH_LOOSE : TH_TIGHT;
    below  = (supply_mv < thresh);
  end

  // Consecutive good-sample counter, saturating; a fault clears it
  always_comb begin
    good_en = below | (good_q != QMAX);
    good_d  = below ? '0 : good_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
    end else if (good_en) begin
      good_q <= good_d;
    end
  end

  assign supply_ok = (good_q == QMAX);

endmodule

// File: rtl/protect_fsm.sv
module protect_fsm
  import bank_guard_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             below,
  input  logic             supply_ok,
  input  logic             ce_n,
  input  logic [SEL_W-1:0] bank_sel,
  output guard_state_t     state,
  output logic [SEL_W-1:0] drain_bank
);

  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYC - 1);

  guard_state_t     st_q, st_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic             tmr_en;
  logic [SEL_W-1:0] bank_q, bank_d;
  logic             bank_en;

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    tmr_en  = 1'b0;
    bank_d  = bank_q;
    bank_en = 1'b0;
    unique case (st_q)
      GS_LOCKED: begin
        // Qualified supply, current sample good, controller idle
        if (supply_ok && !below && ce_n) st_d = GS_RUN;
      end
      GS_RUN: begin
        if (below) begin
          if (!ce_n) begin
            st_d    = GS_DRAIN;
            bank_en = 1'b1;
            bank_d  = bank_sel;
            tmr_en  = 1'b1;
            tmr_d   = '0;
          end else begin
            st_d = GS_LOCKED;
          end
        end
      end
      GS_DRAIN: begin
        if (ce_n || (tmr_q == TLAST)) begin
          st_d = GS_LOCKED;
        end else begin
          tmr_en = 1'b1;
          tmr_d  = tmr_q + 1'b1;
        end
      end
      default: st_d = GS_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= GS_LOCKED;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_en) begin
      bank_q <= bank_d;
    end
  end

  assign state      = st_q;
  assign drain_bank = bank_q;

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int SEL_W     = 2
) (
  input  guard_state_t         state,
  input  logic                 ce_n,
  input  logic [SEL_W-1:0]     bank_sel,
  input  logic [SEL_W-1:0]     drain_bank,
  output logic [NUM_BANKS-1:0] bank_ce_n
);

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    logic hit;
    always_comb begin
      hit = ((state == GS_RUN)   && (bank_sel   == SEL_W'(gi))) ||
            ((state == GS_DRAIN) && (drain_bank == SEL_W'(gi)));
      bank_ce_n[gi] = hit ? ce_n : 1'b1;
    end
  end

endmodule

// File: rtl/sram_bank_guard.sv
module sram_bank_guard
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int SUPPLY_W    = 13,
  parameter int TH_TIGHT_MV = 4620,
  parameter int TH_LOOSE_MV = 4370,
  parameter int TIMEOUT_CYC = 256,
  parameter int VALID_CYC   = 1024,
  localparam int SEL_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_n,
  input  logic [SEL_W-1:0]     bank_sel,
  input  logic [SUPPLY_W-1:0]  supply_mv,
  input  logic                 tol_wide,
  output logic [NUM_BANKS-1:0] bank_ce_n
);

  logic             rst_sync_n;
  logic             fault_below;
  logic             supply_ok;
  guard_state_t     gstate;
  logic [SEL_W-1:0] drain_bank;

  reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  supply_qualifier #(
    .SUPPLY_W    (SUPPLY_W),
    .TH_TIGHT_MV (TH_TIGHT_MV),
    .TH_LOOSE_MV (TH_LOOSE_MV),
    .VALID_CYC   (VALID_CYC)
  ) u_qual (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .supply_mv (supply_mv),
    .tol_wide  (tol_wide),
    .below     (fault_below),
    .supply_ok (supply_ok)
  );

  protect_fsm #(
    .SEL_W       (SEL_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .below      (fault_below),
    .supply_ok  (supply_ok),
    .ce_n       (ce_n),
    .bank_sel   (bank_sel),
    .state      (gstate),
    .drain_bank (drain_bank)
  );

  bank_decoder #(
    .NUM_BANKS (NUM_BANKS),
    .SEL_W     (SEL_W)
  ) u_dec (
    .state      (gstate),
    .ce_n       (ce_n),
    .bank_sel   (bank_sel),
    .drain_bank (drain_bank),
    .bank_ce_n  (bank_ce_n)
  );

endmodule

// File: rtl/sram_bank_guard_chk.sv
module sram_bank_guard_chk
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int TIMEOUT_CYC = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ce_n,
  input logic [NUM_BANKS-1:0] bank_ce_n,
  input guard_state_t         state,
  input logic                 below,
  input logic                 valid
);

  localparam int CW = $clog2(TIMEOUT_CYC + 2);

  // Consecutive cycles already spent draining
  logic [CW-1:0] drain_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_cnt <= '0;
    end else if (state == GS_DRAIN) begin
      drain_cnt <= drain_cnt + 1'b1;
    end else begin
      drain_cnt <= '0;
    end
  end

  a_r1_run_selects_one: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_RUN && !ce_n) |-> ($countones(~bank_ce_n) == 1));

  a_r2_at_most_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~bank_ce_n) <= 1));

  a_r4_idle_fault_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_RUN && below && ce_n) |=> (state == GS_LOCKED));

  a_r5_busy_fault_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_RUN && below && !ce_n) |=> (state == GS_DRAIN));

  a_r6_drain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_DRAIN) |-> (drain_cnt < CW'(TIMEOUT_CYC)));

  a_r7_locked_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_LOCKED) |-> (&bank_ce_n));

  a_r8_exit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_LOCKED && (!valid || below)) |=> (state != GS_RUN));

  a_r10_exit_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_LOCKED && !ce_n) |=> (state != GS_RUN));

endmodule

bind sram_bank_guard sram_bank_guard_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ce_n      (ce_n),
  .bank_ce_n (bank_ce_n),
  .state     (gstate),
  .below     (fault_below),
  .valid     (supply_ok)
);

// File: tb/sram_bank_guard_tb.sv
module sram_bank_guard_tb;

  localparam int TOUT  = 6;
  localparam int VALID = 4;
  localparam int EW    = 21;
  localparam int NVEC  = 8;

  // Entry: {tol_wide, supply_mv[12:0], bank_sel[1:0], ce_n, expected[3:0]}
  localparam logic [NVEC-1:0][EW-1:0] VECS = {
    {1'b1, 13'd4370, 2'd1, 1'b1, 4'b1111},
    {1'b0, 13'd5000, 2'd2, 1'b1, 4'b1111},
    {1'b1, 13'd4400, 2'd3, 1'b0, 4'b0111},
    {1'b1, 13'd4370, 2'd0, 1'b0, 4'b1110},
    {1'b0, 13'd4620, 2'd3, 1'b0, 4'b0111},
    {1'b0, 13'd4620, 2'd2, 1'b0, 4'b1011},
    {1'b0, 13'd5000, 2'd1, 1'b0, 4'b1101},
    {1'b0, 13'd5000, 2'd0, 1'b0, 4'b1110}
  };

  logic        clk;
  logic        rst_n;
  logic        ce_n;
  logic [1:0]  bank_sel;
  logic [12:0] supply_mv;
  logic        tol_wide;
  logic [3:0]  bank_ce_n;

  int checks;
  int failures;
  bit done;

  sram_bank_guard #(
    .TIMEOUT_CYC (TOUT),
    .VALID_CYC   (VALID)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .bank_sel  (bank_sel),
    .supply_mv (supply_mv),
    .tol_wide  (tol_wide),
    .bank_ce_n (bank_ce_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (bank_ce_n !== exp) begin
      failures++;
      $display("FAIL %s: bank_ce_n=%b expected=%b at %0t", req, bank_ce_n, exp, $time);
    end
    checks++;
    if ($countones(~bank_ce_n) > 1) begin
      failures++;
      $display("FAIL R2: bank_ce_n=%b expected at most one low", bank_ce_n);
    end
  endtask

  // Qualify a good supply with the controller idle, ending in pass-through
  task automatic go_run();
    @(negedge clk);
    tol_wide  = 1'b0;
    supply_mv = 13'd5000;
    ce_n      = 1'b1;
    repeat (VALID + 2) @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; ce_n = 1'b0; bank_sel = 2'd0;
    supply_mv = 13'd5000; tol_wide = 1'b0;

    // R9: reset holds every enable high even with ce_n low
    repeat (3) @(negedge clk);
    #1 check("R9 in reset", 4'b1111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R9 after release", 4'b1111);
    go_run();

    // R1/R3: table walk in pass-through
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {tol_wide, supply_mv, bank_sel, ce_n} = VECS[i][EW-1:4];
      #1 check("R1/R3 table", VECS[i][3:0]);
    end

    // R3 wide threshold: 4369 is a fault
    @(negedge clk); tol_wide = 1'b1; supply_mv = 13'd4369; ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; bank_sel = 2'd2;
    #1 check("R3 4369 wide faults", 4'b1111);

    // R4/R7: idle fault at 4619 on tight threshold
    go_run();
    @(negedge clk); supply_mv = 13'd4619; ce_n = 1'b1;
    @(negedge clk); supply_mv = 13'd5000; ce_n = 1'b0; bank_sel = 2'd1;
    #1 check("R4 idle fault locks", 4'b1111);
    ce_n = 1'b1; #0.5 ce_n = 1'b0;
    #0.5 check("R7 falling ce_n ignored", 4'b1111);
    ce_n = 1'b1;

    // R8: dip restarts qualification, then exact exit edge
    @(negedge clk); supply_mv = 13'd4000;
    @(negedge clk); supply_mv = 13'd5000;
    repeat (2) @(negedge clk);
    supply_mv = 13'd4000;
    @(negedge clk); supply_mv = 13'd5000;
    repeat (VALID) @(negedge clk);
    ce_n = 1'b0; bank_sel = 2'd3;
    #1 check("R8 not yet valid", 4'b1111);
    ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    #1 check("R8 exit after qualification", 4'b0111);

    // R5: busy fault freezes bank, select ignored
    @(negedge clk); bank_sel = 2'd1; ce_n = 1'b0;
    @(negedge clk); supply_mv = 13'd4000;
    @(negedge clk); bank_sel = 2'd3;
    #1 check("R5 drain holds bank", 4'b1101);
    ce_n = 1'b1;
    #1 check("R5 drain follows ce_n", 4'b1111);
    @(negedge clk); ce_n = 1'b0;
    #1 check("R5 locked after access", 4'b1111);

    // R10: ce_n held low blocks exit despite valid supply
    @(negedge clk); supply_mv = 13'd5000;
    repeat (VALID + 3) @(negedge clk);
    #1 check("R10 held low stays locked", 4'b1111);
    ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; bank_sel = 2'd2;
    #1 check("R10 exit once idle", 4'b1011);

    // R6: timeout cuts off a stuck access
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); bank_sel = 2'd0; ce_n = 1'b0;
    @(negedge clk); supply_mv = 13'd4000;
    repeat (TOUT) @(negedge clk);
    #1 check("R6 last drain cycle", 4'b1110);
    @(negedge clk);
    #1 check("R6 timeout forces high", 4'b1111);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule